// File: doc/BRIEF.md
# UART interrupt identification

This block sits beside the receive and transmit queues of a byte-wide serial port and decides, once per clock, which of five interrupt causes the port should report. It takes the per-source enable bits, the receiver error flags, data-ready and holding-empty status, the modem-line change flags, the receive queue fill count, the trigger-level selector and the programmed character time. From these it produces a four-bit identification code and an interrupt request. Bus decoding and the queues themselves belong elsewhere.

Two pieces of state live inside the block. The first is a transmit-empty pending flag. It is raised when a byte leaves the transmit queue for the shifter. It is dropped by a write to the holding register, or by a read of the identification code while the transmit-empty cause is enabled. The second is a character-timeout counter. It runs while received data waits unread and reports stale data after four character times. The identification code is registered, so it follows its inputs by one clock.

Top module: `uart_irq_id`

## Requirements
- R1: The causes are ranked, highest first: receiver error (code 0x6), data available (0x4), character timeout (0xC), transmit empty (0x2), modem change (0x0). Only the highest-ranked active cause is reported. Enable bits are `ien[0]` data available and timeout, `ien[1]` transmit empty, `ien[2]` receiver error, `ien[3]` modem change.
- R2: The receiver error cause is active when `ien[2]` is set and any bit of `rx_err` is set. The bits of `rx_err` are {break, framing, parity, overrun}, from bit 3 down to bit 0.
- R3: The data-available cause is active when `ien[0]` is set, `data_ready` is set, and `rx_count` is at or above the trigger level. `trig_sel` values 0, 1, 2 and 3 select levels of 1, 4, 8 and 14 bytes.
- R4: The timeout counter advances on every clock while `data_ready` is high. It returns to zero when `data_ready` is low or `rx_touch` is high. The timeout cause is active when `ien[0]` and `data_ready` are set and the counter is at least 4 × `char_time`. It is therefore reported on the clock after the counter reaches that value.
- R5: The transmit-empty cause is active when `ien[1]`, `thr_empty` and the pending flag are all set. The pending flag is 1 after reset and is set by `tx_load`. It is cleared by `thr_write`; if `tx_load` and `thr_write` arrive together, the flag is set.
- R6: A pulse on `iid_read` clears the pending flag only when `ien[1]` is set. With `ien[1]` clear, the pulse has no effect.
- R7: The modem change cause is active when `ien[3]` is set and any bit of `modem_delta` is set.
- R8: With no active cause, `iid` reads 0x1 and `irq` is low. Whenever `iid` bit 0 is clear, `irq` is high.
- R9: `iid` is registered and shows the result for the inputs present at the previous rising clock edge. During and right after reset, `iid` is 0x1 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien | input | 4 | Per-source interrupt enables |
| rx_err | input | 4 | Receiver error flags {break, framing, parity, overrun} |
| data_ready | input | 1 | Receive queue holds data |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_delta | input | 4 | Modem line change flags |
| rx_count | input | CNT_W | Receive queue fill count |
| trig_sel | input | 2 | Receive trigger level selector |
| char_time | input | CT_W | Clocks per character |
| rx_touch | input | 1 | Receive read or arrival; restarts timeout |
| tx_load | input | 1 | Byte moved from transmit queue to shifter |
| thr_write | input | 1 | Write to the holding register |
| iid_read | input | 1 | Read of the identification code |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
A pending flag that is stuck or missed changes whether 0x2 appears on `iid`. The wrong value shows up two clocks after the write, load or read that should have changed it: one clock for the flag and one for the code register.

A timeout counter that counts wrongly, fails to clear, or uses the wrong multiple moves the first 0xC away from edge 4 × `char_time` + 1, counted from the point where data became ready or was last touched. This is checked at both the edge just before and the edge itself.

A wrong priority or trigger decode shows on the very next edge as a wrong code. The bench sweeps every mix of active causes, every enable pattern, and every trigger setting against every fill count.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    // enable bits, MSB first: modem(3) line(2) thre(1) rxdata(0)
    typedef struct packed {
        logic modem;
        logic line;
        logic thre;
        logic rxdata;
    } ien_t;

    // raw (ungated) cause conditions
    typedef struct packed {
        logic line;
        logic rxdata;
        logic tout;
        logic thre;
        logic modem;
    } cause_t;

    localparam int TO_MULT = 4;

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        case (sel)
            2'd0:    lvl = 5'd1;
            2'd1:    lvl = 5'd4;
            2'd2:    lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uirq_thre_flag.sv
module uirq_thre_flag (
    input  logic clk,
    input  logic rst,
    input  logic tx_load,
    input  logic thr_write,
    input  logic ack_read,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b1;            // queue empty at start
        else if (tx_load)
            pending <= 1'b1;            // load wins over a same-cycle clear
        else if (thr_write || ack_read)
            pending <= 1'b0;
    end
endmodule

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
    parameter int CT_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            data_ready,
    input  logic            rx_touch,
    input  logic [CT_W-1:0] char_time,
    output logic            expired
);
    import uirq_pkg::*;

    localparam int TW = CT_W + $clog2(TO_MULT) + 1;

    logic [TW-1:0] limit;
    logic [TW-1:0] cnt;

    assign limit = TW'(char_time) * TW'(TO_MULT);

    always_ff @(posedge clk) begin
        if (rst || !data_ready || rx_touch)
            cnt <= '0;
        else if (cnt < limit)
            cnt <= cnt + 1'b1;          // saturate at the limit
    end

    assign expired = data_ready && (cnt >= limit);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio (
    input  uirq_pkg::ien_t   en,
    input  uirq_pkg::cause_t cause,
    output uirq_pkg::iid_e   code
);
    import uirq_pkg::*;

    always_comb begin
        if (en.line && cause.line)
            code = IID_LINE;
        else if (en.rxdata && cause.rxdata)
            code = IID_RXDATA;
        else if (en.rxdata && cause.tout)
            code = IID_TIMEOUT;
        else if (en.thre && cause.thre)
            code = IID_THRE;
        else if (en.modem && cause.modem)
            code = IID_MODEM;
        else
            code = IID_NONE;
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
    parameter int CNT_W = 5,
    parameter int CT_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ien,
    input  logic [3:0]       rx_err,
    input  logic             data_ready,
    input  logic             thr_empty,
    input  logic [3:0]       modem_delta,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic [CT_W-1:0]  char_time,
    input  logic             rx_touch,
    input  logic             tx_load,
    input  logic             thr_write,
    input  logic             iid_read,
    output logic [3:0]       iid,
    output logic             irq
);
    import uirq_pkg::*;

    ien_t   en;
    cause_t cause;
    iid_e   code_d;
    iid_e   code_q;
    logic   pend;
    logic   tout;
    logic   lvl_met;

    assign en      = ien_t'(ien);
    assign lvl_met = 32'(rx_count) >= 32'(trig_level(trig_sel));

    uirq_thre_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .tx_load   (tx_load),
        .thr_write (thr_write),
        .ack_read  (iid_read && en.thre),
        .pending   (pend)
    );

    uirq_timeout #(.CT_W(CT_W)) u_tout (
        .clk        (clk),
        .rst        (rst),
        .data_ready (data_ready),
        .rx_touch   (rx_touch),
        .char_time  (char_time),
        .expired    (tout)
    );

    always_comb begin
        cause.line   = |rx_err;
        cause.rxdata = data_ready && lvl_met;
        cause.tout   = tout;
        cause.thre   = thr_empty && pend;
        cause.modem  = |modem_delta;
    end

    uirq_prio u_prio (
        .en    (en),
        .cause (cause),
        .code  (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= IID_NONE;
        else
            code_q <= code_d;
    end

    assign iid = code_q;
    assign irq = ~code_q[0];
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
    parameter int CNT_W = 5,
    parameter int CT_W  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       ien,
    input logic [3:0]       rx_err,
    input logic             data_ready,
    input logic [3:0]       modem_delta,
    input logic [CNT_W-1:0] rx_count,
    input logic [1:0]       trig_sel,
    input logic             tx_load,
    input logic             thr_write,
    input logic [3:0]       iid,
    input logic             irq
);
    import uirq_pkg::*;

    p_code_legal_r1: assert property (@(posedge clk) disable iff (rst)
        iid inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

    p_line_first_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ien[2] && (|rx_err))) |-> iid == 4'h6);

    p_rxdata_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ien[0] && data_ready && !(ien[2] && (|rx_err))
            && (32'(rx_count) >= 32'(trig_level(trig_sel))))) |-> iid == 4'h4);

    p_tout_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!data_ready)) |-> iid != 4'hC);

    p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(thr_write && !tx_load, 2))
            |-> iid != 4'h2);

    p_modem_last_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ien == 4'b1000 && (|modem_delta))) |-> iid == 4'h0);

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ien == 4'b0000)) |-> (iid == 4'h1 && !irq));

    p_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iid == 4'h1 && !irq));
endmodule

bind uart_irq_id uirq_chk #(.CNT_W(CNT_W), .CT_W(CT_W)) u_chk (.*);

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
    localparam int CNT_W = 5;
    localparam int CT_W  = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       ien = '0;
    logic [3:0]       rx_err = '0;
    logic             data_ready = 1'b0;
    logic             thr_empty = 1'b0;
    logic [3:0]       modem_delta = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [1:0]       trig_sel = '0;
    logic [CT_W-1:0]  char_time = CT_W'(200);
    logic             rx_touch = 1'b1;
    logic             tx_load = 1'b0;
    logic             thr_write = 1'b0;
    logic             iid_read = 1'b0;
    logic [3:0]       iid;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uart_irq_id #(.CNT_W(CNT_W), .CT_W(CT_W)) u0 (.*);

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_iid(input string req, input logic [3:0] exp);
        logic exp_irq;
        exp_irq = ~exp[0];
        checks++;
        if (iid !== exp || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b",
                     req, iid, irq, exp, exp_irq);
        end
    endtask

    function automatic logic [3:0] ref_code(input logic [3:0] e, input logic ls,
            input logic rd, input logic to, input logic th, input logic ms);
        if (e[2] && ls)      return 4'h6;
        else if (e[0] && rd) return 4'h4;
        else if (e[0] && to) return 4'hC;
        else if (e[1] && th) return 4'h2;
        else if (e[3] && ms) return 4'h0;
        else                 return 4'h1;
    endfunction

    function automatic int ref_level(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_iid("R9 reset value", 4'h1);
        rst = 1'b0;
        tick(1);
        expect_iid("R9 idle after reset", 4'h1);

        // R1: every mix of four causes, all enabled (pending flag is 1 from reset)
        ien = 4'hF;
        for (int m = 0; m < 16; m++) begin
            rx_err      = m[0] ? 4'b0001 : 4'b0000;
            data_ready  = m[1];
            rx_count    = m[1] ? CNT_W'(1) : '0;
            thr_empty   = m[2];
            modem_delta = m[3] ? 4'b0010 : 4'b0000;
            tick(1);
            expect_iid("R1 priority mix",
                       ref_code(4'hF, m[0], m[1], 1'b0, m[2], m[3]));
        end

        // R1/R8: all causes active, every enable pattern
        rx_err = 4'b1000; data_ready = 1'b1; rx_count = CNT_W'(1);
        thr_empty = 1'b1; modem_delta = 4'b1000;
        for (int e = 0; e < 16; e++) begin
            ien = 4'(e);
            tick(1);
            expect_iid("R8 enable sweep", ref_code(4'(e), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
        end

        // R2: each receiver error bit alone
        ien = 4'b0100; data_ready = 1'b0; thr_empty = 1'b0; modem_delta = '0;
        for (int b = 0; b < 4; b++) begin
            rx_err = 4'(1 << b);
            tick(1);
            expect_iid("R2 error bit", 4'h6);
        end
        rx_err = '0;
        tick(1);
        expect_iid("R2 no error", 4'h1);

        // R7: each modem delta bit alone
        ien = 4'b1000;
        for (int b = 0; b < 4; b++) begin
            modem_delta = 4'(1 << b);
            tick(1);
            expect_iid("R7 modem bit", 4'h0);
        end
        modem_delta = '0;

        // R3: trigger level against every fill count
        ien = 4'b0001; data_ready = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c <= 16; c++) begin
                trig_sel = 2'(s);
                rx_count = CNT_W'(c);
                tick(1);
                expect_iid("R3 trigger", (c >= ref_level(s)) ? 4'h4 : 4'h1);
            end
        end
        data_ready = 1'b0; rx_count = CNT_W'(16); trig_sel = 2'd0;
        tick(1);
        expect_iid("R3 needs data ready", 4'h1);

        // R4: timeout after 4 x char_time clocks with data waiting
        rx_count = '0; char_time = CT_W'(2); data_ready = 1'b1; rx_touch = 1'b0;
        tick(8);
        expect_iid("R4 before limit", 4'h1);
        tick(1);
        expect_iid("R4 at limit", 4'hC);
        rx_count = CNT_W'(1);
        tick(1);
        expect_iid("R1 data over timeout", 4'h4);
        rx_count = '0;
        data_ready = 1'b0;
        tick(1);
        expect_iid("R4 cleared by no data", 4'h1);
        data_ready = 1'b1;
        tick(5);
        rx_touch = 1'b1;
        tick(1);
        rx_touch = 1'b0;
        tick(8);
        expect_iid("R4 restart by touch", 4'h1);
        tick(1);
        expect_iid("R4 limit after touch", 4'hC);
        ien = 4'b0000;
        tick(1);
        expect_iid("R4 timeout disabled", 4'h1);
        ien = 4'b0001; char_time = '0; rx_touch = 1'b1;
        tick(1);
        expect_iid("R4 zero char time", 4'hC);
        data_ready = 1'b0;

        // R5: pending flag
        ien = 4'b0010; thr_empty = 1'b1;
        tick(1);
        expect_iid("R5 pending from reset", 4'h2);
        thr_write = 1'b1;
        tick(1);
        thr_write = 1'b0;
        expect_iid("R5 one edge after write", 4'h2);
        tick(1);
        expect_iid("R5 cleared by write", 4'h1);
        tx_load = 1'b1; thr_write = 1'b1;
        tick(1);
        tx_load = 1'b0; thr_write = 1'b0;
        tick(1);
        expect_iid("R5 load wins over write", 4'h2);
        thr_empty = 1'b0;
        tick(1);
        expect_iid("R5 needs empty", 4'h1);
        thr_empty = 1'b1;

        // R6: identification read acknowledges only when enabled
        iid_read = 1'b1;
        tick(1);
        iid_read = 1'b0;
        tick(1);
        expect_iid("R6 read clears flag", 4'h1);
        tx_load = 1'b1;
        tick(1);
        tx_load = 1'b0;
        tick(1);
        expect_iid("R5 set by load", 4'h2);
        ien = 4'b0000; iid_read = 1'b1;
        tick(1);
        iid_read = 1'b0; ien = 4'b0010;
        tick(1);
        expect_iid("R6 read ignored when disabled", 4'h2);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule